// File: doc/BRIEF.md
# SPI Flash Status Register Engine

This block is the device-side command logic of a serial NOR flash for the status byte. It watches the host's serial clock, chip select and data-in lines through synchronizers clocked by the system clock. It recognises three one-byte commands, and it drives the data-out line with an output enable, so that the line floats whenever the block is not reading.

The status byte is laid out as follows:

| Bit | Meaning |
|-----|---------|
| 7 | Lock bit (can only be set once) |
| 6, 5 | Reserved, read as 0 |
| 4..2 | Protect bits PR2..PR0 |
| 1 | Write-enable latch (WEL) |
| 0 | Busy flag (WIP) |

The protect bits also leave the block on a port for the rest of the device.

Committing a status write starts a self-timed busy period of a parameterised number of system clocks. When that period ends, the write-enable latch clears. Once the lock bit is set, the protect bits and the lock bit can never be written again.

The frame sequencer has seven states:

| State | Meaning |
|-------|---------|
| ST_IDLE | Chip select is high |
| ST_OPCODE | Shifting in the command byte |
| ST_STREAM | Shifting out the status byte repeatedly |
| ST_DATA | Shifting in the status-write data byte |
| ST_ARM_WREN | A write-enable byte is complete and waits for chip select to rise |
| ST_ARM_WRSR | A data byte is complete and waits for chip select to rise |
| ST_DISCARD | The rest of the frame is ignored |

Its transitions are:
- A falling chip select in any state goes to ST_OPCODE.
- A rising chip select in any state goes to ST_IDLE.
- The eighth command bit moves ST_OPCODE to ST_STREAM, ST_ARM_WREN, ST_DATA or ST_DISCARD, depending on the command and the status.
- The eighth data bit moves ST_DATA to ST_ARM_WRSR.
- Any further clock in ST_ARM_WREN or ST_ARM_WRSR goes to ST_DISCARD.
- Leaving ST_ARM_WREN on a rising chip select sets WEL.
- Leaving ST_ARM_WRSR on a rising chip select commits the write.

Top module: `spi_status_engine`

## Requirements
- R1: After reset the status byte reads 0x00, the protect output is 0 and the output enable is low.
- R2: Command 0x05 shifts the status byte out MSB first in SPI mode 0. The output changes after a falling serial clock and the output enable is high only during this read.
- R3: While chip select stays low after 0x05, the status byte repeats every 8 clocks, and each repeat reflects the live WIP and WEL values.
- R4: Command 0x06 sets WEL only if chip select rises after exactly 8 bits. With 9 bits it has no effect.
- R5: Command 0x01 with WEL clear has no effect.
- R6: A committed status write changes only bits 7, 4, 3 and 2. Bits 6 and 5 stay 0, and bits 1 and 0 are not taken from the data.
- R7: A status write whose chip select rises after 7 or 9 data bits is discarded, and WEL stays set.
- R8: A committed write holds WIP at 1 for TW_CYCLES system clocks and then clears WIP and WEL together.
- R9: While WIP is 1, every command except 0x05 is ignored; for example, 0x06 does not set WEL.
- R10: Once bit 7 is 1 it stays 1, and later status writes change nothing, even with WEL set.
- R11: An unrecognised command keeps the output enable low for the rest of the frame and changes no state.
- R12: The protect output always equals status bits 4..2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for so |
| bp | output | 3 | Protect bits PR2..PR0 |

## Verification
The assertions check the following on every cycle:
- WEL never rises while busy.
- WEL is already clear when WIP falls.
- The protect bits change only together with the start of a busy period.
- The lock bit never clears.
- The output is enabled only while chip select is low.

Only the bench scenarios can show the rest:
- The bit-exact framing rules (7, 8 or 9 bits).
- The serial order of the status byte.
- Live WIP values across repeated read bytes.
- That writes are rejected without WEL and after locking.

// File: rtl/spise_pkg.sv
package spise_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_STREAM,
        ST_DATA,
        ST_ARM_WREN,
        ST_ARM_WRSR,
        ST_DISCARD
    } fsm_t;

    localparam logic [7:0] CMD_READ_SR  = 8'h05;
    localparam logic [7:0] CMD_WRITE_SR = 8'h01;
    localparam logic [7:0] CMD_WR_EN    = 8'h06;
endpackage

// File: rtl/spise_sync.sv
module spise_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spise_timer.sv
module spise_timer #(
    parameter int unsigned TW_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(TW_CYCLES + 1);
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= CW'(TW_CYCLES);
            busy <= 1'b1;
        end else if (busy) begin
            cnt <= cnt - CW'(1);
            if (done) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_status_engine.sv
module spi_status_engine #(
    parameter int unsigned TW_CYCLES   = 1000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    output logic       so,
    output logic       so_en,
    output logic [2:0] bp
);
    import spise_pkg::*;

    logic [2:0] pin_s;
    logic       sck_s, cs_s, si_s, sck_d, cs_d;
    logic       sck_rise, sck_fall, cs_rise, cs_fall;

    spise_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din ({sck, cs_n, si}),
        .dout (pin_s)
    );
    assign {sck_s, cs_s, si_s} = pin_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end
    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_rise  = cs_s & ~cs_d;
    assign cs_fall  = ~cs_s & cs_d;

    fsm_t       state, state_nx;
    logic [2:0] bit_cnt, out_cnt;
    logic [6:0] in_sh;
    logic [7:0] out_sh, byte_in, status_live;
    logic [2:0] bp_q, data_bp;
    logic       data_lock, wel, srwd, wip, t_done, commit, wren_go;

    assign byte_in     = {in_sh, si_s};
    assign status_live = {srwd, 2'b00, bp_q, wel, wip};
    assign commit      = cs_rise && (state == ST_ARM_WRSR);
    assign wren_go     = cs_rise && (state == ST_ARM_WREN);

    spise_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
        .clk (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy (wip),
        .done (t_done)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (cs_rise) begin
            state_nx = ST_IDLE;
        end else if (cs_fall) begin
            state_nx = ST_OPCODE;
        end else if (sck_rise) begin
            unique case (state)
                ST_OPCODE: begin
                    if (bit_cnt == 3'd7) begin
                        if (byte_in == CMD_READ_SR)
                            state_nx = ST_STREAM;
                        else if (byte_in == CMD_WR_EN && !wip)
                            state_nx = ST_ARM_WREN;
                        else if (byte_in == CMD_WRITE_SR && !wip && wel && !srwd)
                            state_nx = ST_DATA;
                        else
                            state_nx = ST_DISCARD;
                    end
                end
                ST_DATA:     if (bit_cnt == 3'd7) state_nx = ST_ARM_WRSR;
                ST_ARM_WREN: state_nx = ST_DISCARD;
                ST_ARM_WRSR: state_nx = ST_DISCARD;
                default:     ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift paths and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            out_cnt   <= '0;
            in_sh     <= '0;
            out_sh    <= '0;
            data_bp   <= '0;
            data_lock <= 1'b0;
            bp_q      <= '0;
            srwd      <= 1'b0;
            wel       <= 1'b0;
        end else begin
            if (cs_fall) begin
                bit_cnt <= '0;
                out_cnt <= '0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                in_sh   <= byte_in[6:0];
            end
            if (sck_rise && state == ST_DATA && bit_cnt == 3'd7) begin
                data_bp   <= byte_in[4:2];
                data_lock <= byte_in[7];
            end
            if (sck_fall && state == ST_STREAM) begin
                out_sh  <= (out_cnt == 3'd0) ? status_live : {out_sh[6:0], 1'b0};
                out_cnt <= out_cnt + 3'd1;
            end
            if (commit) begin
                bp_q <= data_bp;
                srwd <= srwd | data_lock;
            end
            if (t_done)       wel <= 1'b0;
            else if (wren_go) wel <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        so    = out_sh[7];
        so_en = (state == ST_STREAM);
        bp    = bp_q;
    end

    a_r9_no_wel_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(wip));
    a_r8_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !wel);
    a_r6_bp_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp_q) |-> $rose(wip));
    a_r10_srwd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srwd) |-> srwd);
    a_r2_so_en_cs: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> !cs_d);
endmodule

// File: tb/sim_spi_status_engine.sv
module sim_spi_status_engine;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic si = 1'b0;
    logic so, so_en;
    logic [2:0] bp;

    int checks = 0;
    int fails = 0;
    bit capture = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string tag;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_status_engine #(.TW_CYCLES(TW)) u0 (
        .clk (clk),
        .rst_n (rst_n),
        .sck (sck),
        .cs_n (cs_n),
        .si (si),
        .so (so),
        .so_en (so_en),
        .bp (bp)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // Monitor: assembles read bytes and compares them with the scoreboard
    logic [7:0] mon_byte = '0;
    int mon_n = 0;
    bit mon_bad = 1'b0;
    always @(posedge sck) begin
        if (capture) begin
            mon_byte = {mon_byte[6:0], so};
            if (!so_en) mon_bad = 1'b1;
            mon_n++;
            if (mon_n == 8) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "scoreboard empty", mon_byte, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(((mon_byte & it.mask) == (it.exp & it.mask)) && !mon_bad,
                          it.tag, {mon_bad, mon_byte}, it.exp);
                end
                mon_n = 0;
                mon_bad = 1'b0;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b);
        @(negedge clk);
        si = b;
        wait_clk(8);
        sck = 1'b1;
        wait_clk(8);
        sck = 1'b0;
    endtask

    task automatic frame_start();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic frame_end();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) spi_bit(v[i]);
    endtask

    // A complete frame: command byte, optional data bits, extra bits
    task automatic cmd(input logic [7:0] op, input logic [7:0] dat,
                       input int dbits, input int extra);
        frame_start();
        send_bits(op, 8);
        if (dbits > 0) send_bits(dat, dbits);
        for (int i = 0; i < extra; i++) spi_bit(1'b0);
        frame_end();
    endtask

    task automatic read_sr(input logic [7:0] e0, input int n, input string tag);
        frame_start();
        send_bits(8'h05, 8);
        capture = 1'b1;
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.exp = e0;
            it.mask = 8'hFF;
            it.tag = tag;
            exp_q.push_back(it);
            send_bits(8'h00, 8);
        end
        capture = 1'b0;
        frame_end();
    endtask

    task automatic push_item(input logic [7:0] e, input logic [7:0] m, input string tag);
        item_t it;
        it.exp = e;
        it.mask = m;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1: reset state
        check(so_en == 1'b0, "R1 so_en after reset", so_en, 0);
        check(bp == 3'd0, "R1 bp after reset", bp, 0);
        read_sr(8'h00, 1, "R1 R2 status after reset");

        // R5: write without WEL is ignored
        cmd(8'h01, 8'h1C, 8, 0);
        read_sr(8'h00, 1, "R5 write without WEL");

        // R4: write enable with 9 bits is ignored, with 8 bits sets WEL
        cmd(8'h06, 8'h00, 0, 1);
        read_sr(8'h00, 1, "R4 WREN with 9 bits");
        cmd(8'h06, 8'h00, 0, 0);
        read_sr(8'h02, 3, "R3 R4 WEL set, repeated bytes");

        // R7: data byte of 7 or 9 bits is discarded
        cmd(8'h01, 8'h1C, 7, 0);
        read_sr(8'h02, 1, "R7 write with 7 data bits");
        cmd(8'h01, 8'h1C, 8, 1);
        read_sr(8'h02, 1, "R7 write with 9 data bits");

        // R6 R8 R3: committed write; poll live across the busy period
        cmd(8'h01, 8'h6F, 8, 0);
        check(bp == 3'd3, "R12 bp after commit", bp, 3);
        frame_start();
        send_bits(8'h05, 8);
        capture = 1'b1;
        push_item(8'h0F, 8'hFF, "R3 R8 poll byte 1 busy");
        send_bits(8'h00, 8);
        push_item(8'h0C, 8'hFC, "R6 poll byte 2");
        send_bits(8'h00, 8);
        push_item(8'h0C, 8'hFC, "R6 poll byte 3");
        send_bits(8'h00, 8);
        push_item(8'h0C, 8'hFF, "R3 R8 poll byte 4 done");
        send_bits(8'h00, 8);
        push_item(8'h0C, 8'hFF, "R8 poll byte 5 done");
        send_bits(8'h00, 8);
        capture = 1'b0;
        frame_end();

        // R9: write enable during busy is ignored
        cmd(8'h06, 8'h00, 0, 0);
        cmd(8'h01, 8'h04, 8, 0);
        cmd(8'h06, 8'h00, 0, 0);
        wait_clk(TW + 50);
        read_sr(8'h04, 1, "R9 WREN during busy ignored");
        check(bp == 3'd1, "R12 bp mirrors status", bp, 1);

        // R11: unknown command, output stays disabled
        frame_start();
        send_bits(8'h9F, 8);
        send_bits(8'hFF, 8);
        check(so_en == 1'b0, "R11 so_en on unknown command", so_en, 0);
        frame_end();
        read_sr(8'h04, 1, "R11 state unchanged");

        // R10: lock bit
        cmd(8'h06, 8'h00, 0, 0);
        cmd(8'h01, 8'hFF, 8, 0);
        wait_clk(TW + 50);
        read_sr(8'h9C, 1, "R6 R10 write 0xFF sets lock");
        check(bp == 3'd7, "R12 bp after lock write", bp, 7);
        cmd(8'h06, 8'h00, 0, 0);
        read_sr(8'h9E, 1, "R10 WEL set while locked");
        cmd(8'h01, 8'h00, 8, 0);
        wait_clk(TW + 50);
        read_sr(8'h9E, 1, "R10 locked write ignored");
        check(bp == 3'd7, "R10 bp unchanged", bp, 7);

        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule